// File: doc/BRIEF.md
# PCI Host Bridge Register Interface

This block is the CPU-facing register file of an on-chip PCI host controller. It sits on a simple 32-bit register bus and decodes a window of 0x224 bytes. The low 256 bytes of the window hold the bridge's own configuration header in local flops. Three control registers sit above the header: a configuration address pointer, a memory base register and an I/O window base register. A data port at the top of the window turns each CPU access into one indirect configuration transaction on a request/response port towards the downstream bus. That transaction targets the address held in the pointer register.

The I/O base register places a 256 KiB window, so only its bits 31:18 select the window. A write to this register is taken only if it moves those bits. Each accepted move is announced to the system address decoder by a one-cycle pulse, which comes with the new base bits. The CPU bus is ready in the same cycle for every local register. For the data port, ready is held low until the downstream side reports completion.

Top module: `pcib_regif`

## Requirements
- R1: Only accesses with all four byte enables set (`cpu_be` = 4'hF) are valid. A narrower access completes in the same cycle, reads return zero, writes change no register, and no downstream transaction starts.
- R2: Aligned offsets 0x000–0x0FC address header dword `offset/4`, which can be written and read back as 32-bit values (dword 0 excepted, see R3).
- R3: Header dword 0 always reads `{DEVICE_ID, VENDOR_ID}` (device in bits 31:16). Writes to it are ignored.
- R4: After reset, header dword 1 reads 0x0290_0080 (command word 0x0080 in bits 15:0, status word 0x0290 in bits 31:16). Every other writable header dword reads 0.
- R5: Offset 0x1C0 is the configuration pointer. All 32 bits are stored and read back, and it resets to 0.
- R6: Offset 0x1C4 is the memory base. A write keeps only `wdata & 0xFF000001`, a read returns that value, and it resets to 0.
- R7: Offset 0x1C8 is the I/O base and resets to 0xFE24_0000. A write is accepted only when its bits 31:18 differ from the stored bits 31:18, and it then stores `wdata & 0xFFFC_0001`. A write that is not accepted leaves all bits unchanged, bit 0 included.
- R8: `io_base` always shows the stored I/O base bits 31:18 (0x3F89 after reset). `io_move` is high for exactly the one cycle after the clock edge that takes an accepted I/O base write, and at no other time.
- R9: A valid write to offset 0x220 raises `cfg_req` with `cfg_we`=1, `cfg_addr` equal to the pointer and `cfg_wdata` equal to the CPU data. These are held stable until `cfg_done`.
- R10: A valid read of offset 0x220 raises `cfg_req` with `cfg_we`=0 and returns the `cfg_rdata` value that was present with `cfg_done`.
- R11: While a data port access is outstanding, `cpu_ready` stays low. It rises in the cycle after the one in which `cfg_done` is sampled high, so a downstream latency of L cycles shows as L+2 wait cycles.
- R12: Offsets that are not decoded (0x100–0x1BC, 0x1CC–0x21C, 0x224 and above) and addresses not aligned to 4 bytes read zero. Writes to them change no register and start no transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 1 | CPU access present; held until `cpu_ready` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset within the window |
| cpu_be | input | 4 | Byte enables; only 4'hF is a valid access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` |
| cpu_ready | output | 1 | Access completes on the clock edge where this is high |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Configuration address (pointer register) |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Downstream completion, one cycle |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_done` |
| io_base | output | 14 | Current I/O window base bits 31:18 |
| io_move | output | 1 | One-cycle pulse when the I/O window moves |

## Verification
The riskiest corner is the I/O base acceptance rule. The bench flips each of the fourteen base bits in turn, and it also writes values that differ only in bits 17:0. A design that compared the whole word would then take an update, change bit 0 and pulse `io_move` when it should not. A design that forgot the mask would keep the low bits. The bench sweeps every header dword to catch an index decode that is off by one, or an identification dword that can be written. It also drives all fifteen partial byte-enable patterns, because a design that ignored the enables would corrupt registers or fire downstream requests. Data port accesses run with downstream latencies from 0 to 3. The bench counts the wait cycles, which exposes a ready that arrives early or a request that drops before completion. Every undecoded offset up to the top of the address space is read and written, to catch aliasing onto a real register.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IOB_LSB  = 18;               // 256 KiB window granule
  localparam int unsigned IOB_W    = WORD_W - IOB_LSB;

  localparam int unsigned OFF_PTR  = 32'h1C0;
  localparam int unsigned OFF_MBR  = 32'h1C4;
  localparam int unsigned OFF_IOB  = 32'h1C8;
  localparam int unsigned OFF_DP   = 32'h220;

  localparam logic [WORD_W-1:0] MBR_KEEP   = 32'hFF00_0001;
  localparam logic [WORD_W-1:0] IOB_KEEP   = 32'hFFFC_0001;
  localparam logic [WORD_W-1:0] IOB_RST    = 32'hFE24_0000;
  localparam logic [WORD_W-1:0] HDR1_RST   = 32'h0290_0080;

  typedef enum logic [1:0] {
    DP_IDLE = 2'd0,
    DP_BUSY = 2'd1,
    DP_DONE = 2'd2
  } dp_state_e;

  typedef struct packed {
    logic hdr;
    logic ptr;
    logic mbr;
    logic iob;
    logic dp;
  } dec_t;

endpackage

// File: rtl/pcib_cfg_hdr.sv
module pcib_cfg_hdr
  import pcib_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 256,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h0B1D,
  localparam int unsigned NUM_DW   = HDR_BYTES / 4,
  localparam int unsigned IDX_W    = $clog2(NUM_DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] hdr_word [NUM_DW];

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
    if (g == 0) begin : g_id
      assign hdr_word[g] = {DEVICE_ID, VENDOR_ID};
    end else begin : g_rw
      localparam logic [WORD_W-1:0] RST_VAL = (g == 1) ? HDR1_RST : '0;
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] word_d;
      logic              word_en;

      always_comb begin
        word_en = wr_en && (idx == IDX_W'(g));
        word_d  = word_en ? wdata : word_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= RST_VAL;
        end else if (word_en) begin
          word_q <= word_d;
        end
      end

      assign hdr_word[g] = word_q;
    end
  end

  assign rdata = hdr_word[idx];

  AST_HDR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx != '0) |=> hdr_word[$past(idx)] == $past(wdata)); // R2

  AST_HDR_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |-> rdata == {DEVICE_ID, VENDOR_ID}); // R3

endmodule

// File: rtl/pcib_ctrl_regs.sv
module pcib_ctrl_regs
  import pcib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ptr,
  input  logic              wr_mbr,
  input  logic              wr_iob,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ptr_q,
  output logic [WORD_W-1:0] mbr_q,
  output logic [WORD_W-1:0] iob_q,
  output logic              move_q
);

  logic [WORD_W-1:0] ptr_d;
  logic [WORD_W-1:0] mbr_d;
  logic [WORD_W-1:0] iob_d;
  logic              move_d;
  logic              iob_accept;

  always_comb begin
    iob_accept = wr_iob && (wdata[WORD_W-1:IOB_LSB] != iob_q[WORD_W-1:IOB_LSB]);
    ptr_d      = wr_ptr     ? wdata            : ptr_q;
    mbr_d      = wr_mbr     ? (wdata & MBR_KEEP) : mbr_q;
    iob_d      = iob_accept ? (wdata & IOB_KEEP) : iob_q;
    move_d     = iob_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mbr_q  <= '0;
      iob_q  <= IOB_RST;
      move_q <= 1'b0;
    end else begin
      if (wr_ptr)     ptr_q <= ptr_d;
      if (wr_mbr)     mbr_q <= mbr_d;
      if (iob_accept) iob_q <= iob_d;
      move_q <= move_d;
    end
  end

  AST_MBR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mbr_q & ~MBR_KEEP) == '0); // R6

  AST_IOB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (iob_q & ~IOB_KEEP) == '0); // R7

  AST_IOB_SAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iob && wdata[WORD_W-1:IOB_LSB] == iob_q[WORD_W-1:IOB_LSB]) |=> $stable(iob_q)); // R7

  AST_MOVE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    move_q |-> iob_q[WORD_W-1:IOB_LSB] != $past(iob_q[WORD_W-1:IOB_LSB])); // R8

endmodule

// File: rtl/pcib_cfg_port.sv
module pcib_cfg_port
  import pcib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [WORD_W-1:0] start_wdata,
  input  logic              cfg_done,
  input  logic [WORD_W-1:0] cfg_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [WORD_W-1:0] cfg_wdata,
  output logic              idle,
  output logic              rdy,
  output logic [WORD_W-1:0] rdata
);

  dp_state_e         state_q, state_d;
  logic              we_q, we_d;
  logic [WORD_W-1:0] wd_q, wd_d;
  logic [WORD_W-1:0] rd_q, rd_d;

  always_comb begin
    state_d = state_q;
    we_d    = we_q;
    wd_d    = wd_q;
    rd_d    = rd_q;
    unique case (state_q)
      DP_IDLE: begin
        if (start) begin
          state_d = DP_BUSY;
          we_d    = start_we;
          wd_d    = start_wdata;
        end
      end
      DP_BUSY: begin
        if (cfg_done) begin
          state_d = DP_DONE;
          rd_d    = we_q ? '0 : cfg_rdata;
        end
      end
      DP_DONE: state_d = DP_IDLE;
      default: state_d = DP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DP_IDLE;
      we_q    <= 1'b0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      wd_q    <= wd_d;
      rd_q    <= rd_d;
    end
  end

  assign cfg_req   = (state_q == DP_BUSY);
  assign cfg_we    = we_q;
  assign cfg_wdata = wd_q;
  assign idle      = (state_q == DP_IDLE);
  assign rdy       = (state_q == DP_DONE);
  assign rdata     = rd_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done) |=> cfg_req && $stable(cfg_we) && $stable(cfg_wdata)); // R9

  AST_DONE_GIVES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_done) |=> rdy && !cfg_req); // R11

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_done && !cfg_we) |=> rdata == $past(cfg_rdata)); // R10

endmodule

// File: rtl/pcib_regif.sv
module pcib_regif
  import pcib_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned HDR_BYTES = 256,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h0B1D,
  localparam int unsigned NUM_DW   = HDR_BYTES / 4,
  localparam int unsigned IDX_W    = $clog2(NUM_DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_ready,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [31:0]       cfg_addr,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_done,
  input  logic [31:0]       cfg_rdata,
  output logic [13:0]       io_base,
  output logic              io_move
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // decode
  dec_t  dec;
  logic  full;
  logic  aligned;
  logic  any_hit;
  logic  wr_fire;

  always_comb begin
    full    = &cpu_be;
    aligned = (cpu_addr[1:0] == 2'b00);
    dec     = '0;
    if (cpu_sel && full && aligned) begin
      dec.hdr = (32'(cpu_addr) < HDR_BYTES);
      dec.ptr = (32'(cpu_addr) == OFF_PTR);
      dec.mbr = (32'(cpu_addr) == OFF_MBR);
      dec.iob = (32'(cpu_addr) == OFF_IOB);
      dec.dp  = (32'(cpu_addr) == OFF_DP);
    end
    any_hit = |dec;
    wr_fire = cpu_sel && cpu_wr && full && aligned;
  end

  // configuration header
  logic [31:0] hdr_rdata;

  pcib_cfg_hdr #(
    .HDR_BYTES (HDR_BYTES),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_hdr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_fire && dec.hdr),
    .idx   (cpu_addr[IDX_W+1:2]),
    .wdata (cpu_wdata),
    .rdata (hdr_rdata)
  );

  // control registers
  logic [31:0] ptr_q, mbr_q, iob_q;
  logic        move_q;

  pcib_ctrl_regs u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_ptr (wr_fire && dec.ptr),
    .wr_mbr (wr_fire && dec.mbr),
    .wr_iob (wr_fire && dec.iob),
    .wdata  (cpu_wdata),
    .ptr_q  (ptr_q),
    .mbr_q  (mbr_q),
    .iob_q  (iob_q),
    .move_q (move_q)
  );

  // data port
  logic        dp_idle, dp_rdy;
  logic [31:0] dp_rdata;

  pcib_cfg_port u_port (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (dec.dp),
    .start_we    (cpu_wr),
    .start_wdata (cpu_wdata),
    .cfg_done    (cfg_done),
    .cfg_rdata   (cfg_rdata),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .idle        (dp_idle),
    .rdy         (dp_rdy),
    .rdata       (dp_rdata)
  );

  // read mux and ready
  always_comb begin
    cpu_rdata = '0;
    if (!cpu_wr) begin
      unique case (1'b1)
        dec.hdr: cpu_rdata = hdr_rdata;
        dec.ptr: cpu_rdata = ptr_q;
        dec.mbr: cpu_rdata = mbr_q;
        dec.iob: cpu_rdata = iob_q;
        dec.dp:  cpu_rdata = dp_rdy ? dp_rdata : '0;
        default: cpu_rdata = '0;
      endcase
    end
    cpu_ready = dec.dp ? dp_rdy : cpu_sel;
  end

  assign cfg_addr = ptr_q;
  assign io_base  = iob_q[31:IOB_LSB];
  assign io_move  = move_q;

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_sel && !full) |-> cpu_ready && cpu_rdata == '0); // R1

  AST_NARROW_NO_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_sel && !full && dp_idle) |=> !cfg_req); // R1

  AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_sel && !any_hit) |-> cpu_rdata == '0); // R12

  AST_DP_STALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_req |-> !cpu_ready); // R11

endmodule

// File: tb/test_pcib_regif.sv
module test_pcib_regif;

  localparam logic [15:0] VEN = 16'hC0DE;
  localparam logic [15:0] DEV = 16'h0B1D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_sel = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_done = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic [13:0] io_base;
  logic        io_move;

  always #2.5 clk = ~clk;

  pcib_regif #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) i_pcib_regif (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cfg_req(cfg_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_done(cfg_done), .cfg_rdata(cfg_rdata), .io_base(io_base),
    .io_move(io_move)
  );

  int nvec = 0;
  int nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // downstream responder
  int          lat = 0;
  int          rcnt = 0;
  int          txn = 0;
  logic        last_we;
  logic [31:0] last_addr, last_wdata;

  function automatic logic [31:0] resp(input logic [31:0] a);
    return ~a + 32'h0101_0101;
  endfunction

  always @(negedge clk) begin
    if (cfg_done) begin
      cfg_done = 1'b0;
    end else if (cfg_req) begin
      if (rcnt == lat) begin
        cfg_done   = 1'b1;
        cfg_rdata  = resp(cfg_addr);
        txn++;
        last_we    = cfg_we;
        last_addr  = cfg_addr;
        last_wdata = cfg_wdata;
        rcnt = 0;
      end else begin
        rcnt++;
      end
    end
  end

  // window move monitor
  int          pulses = 0;
  int          doubles = 0;
  logic        prev_move = 1'b0;
  logic [13:0] last_io = '0;

  always @(negedge clk) begin
    if (io_move) begin
      pulses++;
      last_io = io_base;
      if (prev_move) doubles++;
    end
    prev_move = io_move;
  end

  task automatic acc(input logic wr, input logic [9:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    #1;
    waits = 0;
    while (!cpu_ready && waits < 50) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_be = '0;
    #1;
  endtask

  task automatic wr32(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] r; int w;
    acc(1'b1, a, 4'hF, d, r, w);
  endtask

  task automatic rd32(input logic [9:0] a, output logic [31:0] d);
    int w;
    acc(1'b0, a, 4'hF, '0, d, w);
  endtask

  function automatic logic [31:0] hpat(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ {16'(i), 16'(~i)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, cur, nv, ex;
    int w, t0, p0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd32(10'h1C0, r); chk("R5 ptr reset", r, 32'h0);
    rd32(10'h1C4, r); chk("R6 mbr reset", r, 32'h0);
    rd32(10'h1C8, r); chk("R7 iob reset", r, 32'hFE24_0000);
    chk("R8 io_base reset", 32'(io_base), 32'h3F89);
    chk("R8 no pulse at reset", 32'(pulses), 32'd0);
    chk("R9 no req at reset", 32'(cfg_req), 32'd0);
    rd32(10'h000, r); chk("R3 id dword", r, {DEV, VEN});
    rd32(10'h004, r); chk("R4 cmd/status reset", r, 32'h0290_0080);
    for (int i = 2; i < 64; i++) begin
      rd32(10'(i * 4), r); chk("R4 hdr reset zero", r, 32'h0);
    end

    // header sweep
    for (int i = 0; i < 64; i++) wr32(10'(i * 4), hpat(i));
    for (int i = 0; i < 64; i++) begin
      rd32(10'(i * 4), r);
      if (i == 0) chk("R3 id write ignored", r, {DEV, VEN});
      else        chk("R2 hdr readback", r, hpat(i));
    end

    // pointer and memory base
    wr32(10'h1C0, 32'hFFFF_FFFF); rd32(10'h1C0, r); chk("R5 ptr all ones", r, 32'hFFFF_FFFF);
    wr32(10'h1C0, 32'h1234_5678); rd32(10'h1C0, r); chk("R5 ptr pattern", r, 32'h1234_5678);
    wr32(10'h1C4, 32'hFFFF_FFFF); rd32(10'h1C4, r); chk("R6 mbr mask ones", r, 32'hFF00_0001);
    wr32(10'h1C4, 32'h1234_5678); rd32(10'h1C4, r); chk("R6 mbr mask pattern", r, 32'h1200_0000);

    // narrow accesses
    t0 = txn;
    for (int b = 0; b < 15; b++) begin
      acc(1'b1, 10'h1C0, 4'(b), 32'hDEAD_BEEF, r, w);
      acc(1'b1, 10'h008, 4'(b), 32'hDEAD_BEEF, r, w);
      acc(1'b1, 10'h220, 4'(b), 32'hDEAD_BEEF, r, w);
      chk("R1 narrow dp write no stall", 32'(w), 32'd0);
      acc(1'b0, 10'h1C0, 4'(b), 32'h0, r, w);
      chk("R1 narrow read zero", r, 32'h0);
      chk("R1 narrow no wait", 32'(w), 32'd0);
    end
    rd32(10'h1C0, r); chk("R1 ptr untouched", r, 32'h1234_5678);
    rd32(10'h008, r); chk("R1 hdr untouched", r, hpat(2));
    chk("R1 no downstream txn", 32'(txn - t0), 32'd0);

    // I/O base acceptance
    p0 = pulses;
    wr32(10'h1C8, 32'hFE27_FFFF); rd32(10'h1C8, r);
    chk("R7 same base ignored", r, 32'hFE24_0000);
    chk("R8 no pulse on ignore", 32'(pulses - p0), 32'd0);
    wr32(10'h1C8, 32'h1234_5677); rd32(10'h1C8, r);
    chk("R7 accepted masked", r, 32'h1234_0001);
    chk("R8 one pulse", 32'(pulses - p0), 32'd1);
    chk("R8 pulse base", 32'(last_io), 32'h048D);
    wr32(10'h1C8, 32'h1237_0000); rd32(10'h1C8, r);
    chk("R7 low bits only ignored, bit0 kept", r, 32'h1234_0001);
    chk("R8 no pulse on low change", 32'(pulses - p0), 32'd1);
    cur = 32'h1234_0001;
    for (int k = 0; k < 14; k++) begin
      p0 = pulses;
      nv = (cur ^ (32'h1 << (18 + k))) | 32'h0002_FFFE;
      nv[0] = k[0];
      ex = nv & 32'hFFFC_0001;
      wr32(10'h1C8, nv); rd32(10'h1C8, r);
      chk("R7 bit flip accepted", r, ex);
      chk("R8 pulse per move", 32'(pulses - p0), 32'd1);
      chk("R8 io_base follows", 32'(io_base), 32'(ex[31:18]));
      cur = ex;
    end
    chk("R8 pulse one cycle wide", 32'(doubles), 32'd0);

    // data port
    for (int l = 0; l < 4; l++) begin
      lat = l;
      wr32(10'h1C0, 32'h8000_1000 + 32'(l * 4));
      t0 = txn;
      acc(1'b1, 10'h220, 4'hF, 32'hA5A5_0000 + 32'(l), r, w);
      chk("R9 one txn", 32'(txn - t0), 32'd1);
      chk("R9 we", 32'(last_we), 32'd1);
      chk("R9 addr", last_addr, 32'h8000_1000 + 32'(l * 4));
      chk("R9 wdata", last_wdata, 32'hA5A5_0000 + 32'(l));
      chk("R11 write wait", 32'(w), 32'(l + 2));
      acc(1'b0, 10'h220, 4'hF, 32'h0, r, w);
      chk("R10 we low", 32'(last_we), 32'd0);
      chk("R10 read data", r, resp(32'h8000_1000 + 32'(l * 4)));
      chk("R11 read wait", 32'(w), 32'(l + 2));
    end
    rd32(10'h1C0, r); chk("R5 ptr after dp", r, 32'h8000_100C);

    // undecoded and misaligned
    t0 = txn; p0 = pulses;
    for (int a = 10'h100; a < 1024; a += 4) begin
      if (a == 10'h1C0 || a == 10'h1C4 || a == 10'h1C8 || a == 10'h220) continue;
      rd32(10'(a), r); chk("R12 undecoded read zero", r, 32'h0);
      wr32(10'(a), 32'hFFFF_FFFF);
    end
    for (int m = 1; m < 4; m++) begin
      rd32(10'(10'h1C0 + m), r); chk("R12 misaligned read zero", r, 32'h0);
      wr32(10'(10'h1C0 + m), 32'h0);
      wr32(10'(10'h1C8 + m), 32'h0);
      wr32(10'(10'h220 + m), 32'h0);
      wr32(10'(10'h008 + m), 32'h0);
    end
    rd32(10'h1C0, r); chk("R12 ptr unchanged", r, 32'h8000_100C);
    rd32(10'h1C4, r); chk("R12 mbr unchanged", r, 32'h1200_0000);
    rd32(10'h1C8, r); chk("R12 iob unchanged", r, cur);
    rd32(10'h008, r); chk("R12 hdr unchanged", r, hpat(2));
    rd32(10'h0FC, r); chk("R12 hdr top unchanged", r, hpat(63));
    chk("R12 no txn", 32'(txn - t0), 32'd0);
    chk("R12 no pulse", 32'(pulses - p0), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule